// File: doc/BRIEF.md
# H-tree combining switch between compute ports and memory banks

This block connects NPORT compute ports, one per small systolic array, to NPORT memory-bank ports through a binary tree of registered routing nodes. Any compute port can reach any bank, and the path length grows with log2(NPORT) rather than with the port count. Each transfer is set up beforehand through a small register interface. The setup chooses the direction, a bank index, a two-bit code for every tree node, and a fanout mask for reads.

In read mode, words from the chosen bank climb the tree and are then steered down to every compute port set in the fanout mask. In write mode, partial-result vectors travel upward from the compute ports. Each tree node either forwards one child or adds both children lane by lane with saturation. The single surviving vector at the root is then steered down to the chosen bank. Because of this, the partial results of any subset of arrays can be reduced to one bank write. A node set to add holds back a child that arrives early until its partner arrives. Busy stays high while anything is in flight, and configuration writes made during that time are dropped.

Top module: `htree_combine_switch`

## Requirements
- R1: After a synchronous active-low reset, busy is 0, cp_ready is all zero, and no valid is raised on cp_rvalid or mb_wvalid.
- R2: In read mode (mode bit 0 of control register 0 cleared), a word offered on mb_rdata by the bank whose index sits in control bits [8 +: log2(NPORT)] appears on cp_rdata 2*log2(NPORT) cycles later. At that time cp_rvalid equals the fanout mask (register 2, bits [NPORT-1:0]). Back-to-back words stream one per cycle, and other banks are ignored.
- R3: In write mode (mode bit set), a single port routed by pass nodes reaches the indexed bank. The bank's one-hot mb_wvalid bit is raised and the data is unchanged, 2*log2(NPORT) cycles after acceptance.
- R4: Node codes (register 1, node n at bits [2(n-1) +: 2], node 1 the root, children of n are 2n and 2n+1, port i under node (NPORT+i)/2 on the left when i is even) are 0 idle, 1 pass left, 2 pass right and 3 add. Add nodes sum their children lane by lane, so any subset of ports, adjacent or not, reaches the bank as one word.
- R5: Each add treats the vector as LANES signed LW-bit lanes. It clamps each lane to the largest or smallest value instead of wrapping, at every node where a sum is formed.
- R6: When only one child of an add node holds a valid word, that child is stalled: its cp_ready is low, or the child node keeps its word. This lasts until the other child is valid. The sum then leaves 2*log2(NPORT) cycles after the later word was accepted.
- R7: Busy is high while any word is inside the switch. Configuration writes made while busy have no effect on routing, destination or mode.
- R8: In read mode, compute-port inputs are ignored: cp_ready stays low and mb_wvalid stays zero.
- R9: Ports beneath an idle or unselected branch see cp_ready low, and their data never reaches a bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 node codes, 2 fanout mask |
| cfg_wdata | input | 32 | Configuration write data |
| busy | output | 1 | Words in flight; configuration locked |
| cp_wvalid | input | NPORT | Per compute port: partial-result vector valid |
| cp_wdata | input | NPORT*LANES*LW | Per compute port partial-result vectors, port i at slice i |
| cp_ready | output | NPORT | Per compute port: vector accepted this cycle |
| cp_rvalid | output | NPORT | Per compute port: read word delivered |
| cp_rdata | output | LANES*LW | Read word delivered to compute ports |
| mb_rvalid | input | NPORT | Per bank: read word offered |
| mb_rdata | input | NPORT*LANES*LW | Per bank read words, bank i at slice i |
| mb_wvalid | output | NPORT | One-hot bank write strobe |
| mb_wdata | output | LANES*LW | Combined word written to the selected bank |

## Verification
The hardest state to reach from the ports is an add node holding one half of a sum while its partner is absent. That situation also keeps busy high long enough to try a configuration change in the middle of a transfer. The bench reaches it by offering three of four ports together, releasing the two that were taken, and holding the third until the fourth appears several cycles later. While waiting, it writes a new destination and new node codes. A further case sends vectors whose lanes overflow in opposite directions at the two lower nodes. This makes the saturated per-node result differ visibly from a flat sum.

// File: rtl/htree_combine_switch.sv
module htree_combine_switch #(
  parameter int NPORT = 4,
  parameter int LANES = 8,
  parameter int LW    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic                        busy,
  input  logic [NPORT-1:0]            cp_wvalid,
  input  logic [NPORT*LANES*LW-1:0]   cp_wdata,
  output logic [NPORT-1:0]            cp_ready,
  output logic [NPORT-1:0]            cp_rvalid,
  output logic [LANES*LW-1:0]         cp_rdata,
  input  logic [NPORT-1:0]            mb_rvalid,
  input  logic [NPORT*LANES*LW-1:0]   mb_rdata,
  output logic [NPORT-1:0]            mb_wvalid,
  output logic [LANES*LW-1:0]         mb_wdata
);
  localparam int LEV = $clog2(NPORT);
  localparam int VW  = LANES * LW;
  localparam int IW  = LEV;
  localparam int NCW = 2 * (NPORT - 1);

  logic             mode_wr;
  logic [IW-1:0]    bank_idx;
  logic [NCW-1:0]   node_cfg;
  logic [NPORT-1:0] rd_mask;
  logic [NPORT-1:0] nv;
  logic [LEV-1:0]   up_v, dn_v;
  logic [VW-1:0]    up_d [LEV];
  logic [VW-1:0]    dn_d [LEV];
  logic             cfg_unused;

  assign cfg_unused = ^cfg_wdata;

  function automatic logic [VW-1:0] sat_add(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] r;
    logic [LW:0]   s;
    r = '0;
    for (int k = 0; k < LANES; k++) begin
      s = {a[k*LW+LW-1], a[k*LW +: LW]} + {b[k*LW+LW-1], b[k*LW +: LW]};
      if (s[LW] != s[LW-1]) r[k*LW +: LW] = {s[LW], {(LW-1){~s[LW]}}};
      else                  r[k*LW +: LW] = s[LW-1:0];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_wr  <= 1'b0;
      bank_idx <= '0;
      node_cfg <= '0;
      rd_mask  <= '0;
    end else if (cfg_we && !busy) begin
      case (cfg_addr)
        2'd0: begin
          mode_wr  <= cfg_wdata[0];
          bank_idx <= cfg_wdata[8 +: IW];
        end
        2'd1:    node_cfg <= cfg_wdata[NCW-1:0];
        2'd2:    rd_mask  <= cfg_wdata[NPORT-1:0];
        default: ;
      endcase
    end
  end

  assign nv[0] = 1'b0;

  for (genvar n = 1; n < NPORT; n++) begin : g_nd
    logic          v, lv, rv, pop, rdy, tl, tr;
    logic [VW-1:0] d, ld, rd;
    logic [1:0]    c;

    assign c = node_cfg[2*(n-1) +: 2];

    if (n >= NPORT/2) begin : g_bot
      assign lv = mode_wr & cp_wvalid[2*n-NPORT];
      assign rv = mode_wr & cp_wvalid[2*n-NPORT+1];
      assign ld = cp_wdata[(2*n-NPORT)*VW +: VW];
      assign rd = cp_wdata[(2*n-NPORT+1)*VW +: VW];
      assign cp_ready[2*n-NPORT]   = tl;
      assign cp_ready[2*n-NPORT+1] = tr;
    end else begin : g_mid
      assign lv = g_nd[2*n].v;
      assign rv = g_nd[2*n+1].v;
      assign ld = g_nd[2*n].d;
      assign rd = g_nd[2*n+1].d;
    end

    if (n == 1) begin : g_top
      assign pop = 1'b1;
    end else if (n % 2 == 0) begin : g_lft
      assign pop = g_nd[n/2].tl;
    end else begin : g_rgt
      assign pop = g_nd[n/2].tr;
    end

    assign rdy = ~v | pop;

    always_comb begin
      tl = 1'b0;
      tr = 1'b0;
      case (c)
        2'd1: tl = lv & rdy;
        2'd2: tr = rv & rdy;
        2'd3: begin
          tl = lv & rv & rdy;
          tr = lv & rv & rdy;
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v <= 1'b0;
        d <= '0;
      end else if (tl | tr) begin
        v <= 1'b1;
        d <= (c == 2'd3) ? sat_add(ld, rd) : (tl ? ld : rd);
      end else if (pop) begin
        v <= 1'b0;
      end
    end

    assign nv[n] = v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_v <= '0;
      dn_v <= '0;
      for (int i = 0; i < LEV; i++) begin
        up_d[i] <= '0;
        dn_d[i] <= '0;
      end
    end else begin
      up_v[0] <= ~mode_wr & mb_rvalid[bank_idx];
      up_d[0] <= mb_rdata[bank_idx*VW +: VW];
      dn_v[0] <= mode_wr ? g_nd[1].v : up_v[LEV-1];
      dn_d[0] <= mode_wr ? g_nd[1].d : up_d[LEV-1];
      for (int i = 1; i < LEV; i++) begin
        up_v[i] <= up_v[i-1];
        up_d[i] <= up_d[i-1];
        dn_v[i] <= dn_v[i-1];
        dn_d[i] <= dn_d[i-1];
      end
    end
  end

  assign busy      = (|nv) | (|up_v) | (|dn_v);
  assign cp_rvalid = (dn_v[LEV-1] & ~mode_wr) ? rd_mask : '0;
  assign mb_wvalid = (dn_v[LEV-1] & mode_wr) ? (NPORT'(1) << bank_idx) : '0;
  assign cp_rdata  = dn_d[LEV-1];
  assign mb_wdata  = dn_d[LEV-1];
endmodule

module htree_combine_switch_chk #(
  parameter int NPORT = 4,
  parameter int IW    = 2,
  parameter int NCW   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mode_wr,
  input logic [IW-1:0]    bank_idx,
  input logic [NCW-1:0]   node_cfg,
  input logic [NPORT-1:0] rd_mask,
  input logic [NPORT-1:0] cp_ready,
  input logic [NPORT-1:0] cp_rvalid,
  input logic [NPORT-1:0] mb_wvalid
);
  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mb_wvalid));

  assert_dir_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((|cp_rvalid) && (|mb_wvalid)));

  assert_no_accept_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |-> (cp_ready == '0));

  assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(node_cfg) && $stable(bank_idx) && $stable(mode_wr) && $stable(rd_mask)));

  assert_out_was_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mb_wvalid) || (|cp_rvalid)) |-> $past(busy));
endmodule

bind htree_combine_switch htree_combine_switch_chk #(
  .NPORT(NPORT), .IW(IW), .NCW(NCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mode_wr(mode_wr), .bank_idx(bank_idx),
  .node_cfg(node_cfg), .rd_mask(rd_mask), .cp_ready(cp_ready),
  .cp_rvalid(cp_rvalid), .mb_wvalid(mb_wvalid)
);

// File: tb/htree_combine_switch_tb_top.sv
module htree_combine_switch_tb_top;
  localparam int N   = 4;
  localparam int LAT = 4;
  localparam int VW  = 128;
  localparam int EXN = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          busy;
  logic [N-1:0]  cp_wvalid = '0, mb_rvalid = '0;
  logic [N-1:0]  cp_ready, cp_rvalid, mb_wvalid;
  logic [N*VW-1:0] cp_wdata = '0, mb_rdata = '0;
  logic [VW-1:0] cp_rdata, mb_wdata;

  int    cyc = 0, total = 0, bad = 0;
  bit    done = 1'b0;
  string cur = "R1";
  logic [N-1:0]  exp_wv [EXN];
  logic [N-1:0]  exp_rv [EXN];
  logic [VW-1:0] exp_d  [EXN];
  logic [VW-1:0] pw [N];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  htree_combine_switch #(.NPORT(N), .LANES(8), .LW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .cp_wvalid(cp_wvalid), .cp_wdata(cp_wdata), .cp_ready(cp_ready),
    .cp_rvalid(cp_rvalid), .cp_rdata(cp_rdata), .mb_rvalid(mb_rvalid), .mb_rdata(mb_rdata),
    .mb_wvalid(mb_wvalid), .mb_wdata(mb_wdata)
  );

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] expv, string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, expv);
    end
  endtask

  function automatic logic [VW-1:0] vfill(int base, int step);
    logic [VW-1:0] r;
    for (int k = 0; k < 8; k++) r[k*16 +: 16] = 16'(base + k*step);
    return r;
  endfunction

  function automatic logic [VW-1:0] sadd(logic [VW-1:0] a, logic [VW-1:0] b);
    logic [VW-1:0] r;
    for (int k = 0; k < 8; k++) begin
      int x;
      x = int'($signed(a[k*16 +: 16])) + int'($signed(b[k*16 +: 16]));
      if (x > 32767) x = 32767;
      if (x < -32768) x = -32768;
      r[k*16 +: 16] = 16'(x);
    end
    return r;
  endfunction

  task automatic cfgw(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_ports();
    for (int i = 0; i < N; i++) cp_wdata[i*VW +: VW] = pw[i];
  endtask

  task automatic exp_write(int at, logic [N-1:0] m, logic [VW-1:0] d);
    exp_wv[at] = m; exp_d[at] = d;
  endtask

  task automatic exp_read(int at, logic [N-1:0] m, logic [VW-1:0] d);
    exp_rv[at] = m; exp_d[at] = d;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // cycle-by-cycle comparison against the scheduled reference outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur, VW'(mb_wvalid), VW'(exp_wv[cyc]), "mb_wvalid");
      check(cur, VW'(cp_rvalid), VW'(exp_rv[cyc]), "cp_rvalid");
      if (exp_wv[cyc] != '0) check(cur, mb_wdata, exp_d[cyc], "mb_wdata");
      if (exp_rv[cyc] != '0) check(cur, cp_rdata, exp_d[cyc], "cp_rdata");
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < EXN; i++) begin exp_wv[i] = '0; exp_rv[i] = '0; exp_d[i] = '0; end
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", VW'(busy), 0, "busy after reset");
    check("R1", VW'(cp_ready), 0, "cp_ready after reset");
    check("R1", VW'(mb_wvalid), 0, "mb_wvalid after reset");
    check("R1", VW'(cp_rvalid), 0, "cp_rvalid after reset");

    // R2 / R8: read from bank 2, fanout 1011, compute ports pushing meanwhile
    cur = "R2";
    cfgw(2'd0, 32'h0000_0200);
    cfgw(2'd2, 32'h0000_000B);
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < N; b++) mb_rdata[b*VW +: VW] = vfill(100*b + 10*k, b + 1);
      mb_rvalid = 4'hF;
      for (int i = 0; i < N; i++) pw[i] = vfill(7 + i, 1);
      load_ports();
      cp_wvalid = 4'hF;
      exp_read(cyc + LAT, 4'hB, vfill(200 + 10*k, 3));
      #1 check("R8", VW'(cp_ready), 0, "cp_ready in read mode");
      @(negedge clk);
    end
    mb_rvalid = '0; cp_wvalid = '0;
    idle(8);
    cfgw(2'd0, 32'h0000_0000);
    cfgw(2'd2, 32'h0000_0004);
    for (int b = 0; b < N; b++) mb_rdata[b*VW +: VW] = vfill(-50*b - 3, -7);
    mb_rvalid = 4'b0001;
    exp_read(cyc + LAT, 4'b0100, vfill(-3, -7));
    @(negedge clk);
    mb_rvalid = '0;
    idle(8);

    // R4 / R5: all four ports summed into bank 1
    cur = "R4";
    cfgw(2'd1, 32'h0000_003F);
    cfgw(2'd0, 32'h0000_0101);
    for (int k = 0; k < 5; k++) begin
      if (k < 3) begin
        for (int i = 0; i < N; i++) pw[i] = vfill(1000*i + 5*k - 1500, i - 2);
      end else if (k == 3) begin
        cur = "R5";
        pw[0] = vfill(30000, -1000); pw[1] = vfill(30000, 0);
        pw[2] = vfill(-5000, -3000); pw[3] = vfill(-30000, 0);
      end else begin
        pw[0] = vfill(20000, 0); pw[1] = vfill(15000, 0);
        pw[2] = vfill(1, 1);     pw[3] = vfill(1, 0);
      end
      load_ports();
      cp_wvalid = 4'hF;
      exp_write(cyc + LAT, 4'b0010, sadd(sadd(pw[0], pw[1]), sadd(pw[2], pw[3])));
      #1 check("R4", VW'(cp_ready), VW'(4'hF), "cp_ready full add");
      @(negedge clk);
    end
    cp_wvalid = '0;
    idle(8);

    // R3 / R9: port 2 alone to bank 3 through pass nodes, node 2 idle
    cur = "R3";
    cfgw(2'd1, 32'h0000_0012);
    cfgw(2'd0, 32'h0000_0301);
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < N; i++) pw[i] = vfill(-400*i + k, 11);
      load_ports();
      cp_wvalid = 4'hF;
      exp_write(cyc + LAT, 4'b1000, pw[2]);
      #1 check("R9", VW'(cp_ready), VW'(4'b0100), "cp_ready pass port 2");
      @(negedge clk);
    end
    cp_wvalid = '0;
    idle(8);

    // R3: port 1 alone to bank 2
    cfgw(2'd1, 32'h0000_0009);
    cfgw(2'd0, 32'h0000_0201);
    for (int i = 0; i < N; i++) pw[i] = vfill(3000 + i, -13);
    load_ports();
    cp_wvalid = 4'hF;
    exp_write(cyc + LAT, 4'b0100, pw[1]);
    #1 check("R3", VW'(cp_ready), VW'(4'b0010), "cp_ready pass port 1");
    @(negedge clk);
    cp_wvalid = '0;
    idle(8);

    // R4: non-adjacent ports 0 and 3 summed into bank 0
    cur = "R4";
    cfgw(2'd1, 32'h0000_0027);
    cfgw(2'd0, 32'h0000_0001);
    for (int i = 0; i < N; i++) pw[i] = vfill(250*i - 600, 17 - 4*i);
    load_ports();
    cp_wvalid = 4'hF;
    exp_write(cyc + LAT, 4'b0001, sadd(pw[0], pw[3]));
    #1 check("R4", VW'(cp_ready), VW'(4'b1001), "cp_ready subset 0,3");
    @(negedge clk);
    cp_wvalid = '0;
    idle(8);

    // R6 / R7: port 3 late; node 3 stalls port 2; config change while busy is dropped
    cur = "R6";
    cfgw(2'd1, 32'h0000_003F);
    cfgw(2'd0, 32'h0000_0101);
    pw[0] = vfill(111, 2); pw[1] = vfill(-222, 5); pw[2] = vfill(31000, 100); pw[3] = vfill(4000, 0);
    load_ports();
    cp_wvalid = 4'b0111;
    #1 check("R6", VW'(cp_ready), VW'(4'b0011), "cp_ready with port 3 absent");
    @(negedge clk);
    cp_wvalid = 4'b0100;
    #1 check("R6", VW'(cp_ready), 0, "port 2 stalled");
    check("R7", VW'(busy), 1, "busy while half sum held");
    cur = "R7";
    cfgw(2'd1, 32'h0000_0000);
    cfgw(2'd0, 32'h0000_0300);
    cur = "R6";
    #1 check("R6", VW'(cp_ready), 0, "port 2 still stalled");
    @(negedge clk);
    cp_wvalid = 4'b1100;
    exp_write(cyc + LAT, 4'b0010, sadd(sadd(pw[0], pw[1]), sadd(pw[2], pw[3])));
    #1 check("R6", VW'(cp_ready), VW'(4'b1100), "late partner releases port 2");
    @(negedge clk);
    cp_wvalid = '0;
    idle(8);
    check("R7", VW'(busy), 0, "busy after drain");

    // R7: earlier write attempts left the add-all, bank 1 setup in place
    cur = "R7";
    for (int i = 0; i < N; i++) pw[i] = vfill(-9 * i, 3);
    load_ports();
    cp_wvalid = 4'hF;
    exp_write(cyc + LAT, 4'b0010, sadd(sadd(pw[0], pw[1]), sadd(pw[2], pw[3])));
    #1 check("R7", VW'(cp_ready), VW'(4'hF), "setup unchanged after busy write");
    @(negedge clk);
    cp_wvalid = '0;
    idle(8);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule